// File: doc/BRIEF.md
# CAN controller register interface

This block is the register front end of a CAN controller that has a single frame buffer. A host reaches it over a simple 32-bit bus. The bus uses word addresses, a write strobe and a read strobe. The block holds the controller's operating configuration and drives a level interrupt. It also passes one-cycle command pulses, the mode and timing settings, and the acceptance filter values to a protocol engine. The engine itself is outside this block. In return, the engine reports events, live status bits, bus error details, error counter values and received frame bytes.

A mode bit called reset mode gates the configuration. While it is set, software may change the timing, the warning limit, the upper mode bits and the acceptance filter. When it is clear, those registers are frozen and the buffer window carries frame bytes. Transmit bytes and receive bytes share one address range, but each direction has its own storage.

Top module: `can_regif`

## Requirements
- R1: After reset the registers read as follows: mode 0x01, status 0x3C, interrupt flags 0, interrupt enables 0, bit timing 0, warning limit 0x60, error counters 0. `irq_o` is low.
- R2: Mode is at word 0x00, with bit 0 reset mode, bit 1 listen-only, bit 2 loopback, bit 3 single filter and bit 4 sleep. Bit 0 takes every write. Bits 4:1 take a write only when bit 0 was 1 before that write. `mode_o` shows the stored value.
- R3: Bit timing is at word 0x05 and the warning limit is at word 0x06 (8 bits). Both accept writes only in reset mode. Bit timing keeps only the bits in mask 0x00FFC3FF: prescaler-1 in 9:0, jump-1 in 15:14, segment1-1 in 19:16, segment2-1 in 22:20 and triple sampling in 23. All other bits read 0.
- R4: A write to word 0x01 drives `cmd_o` = wdata[5:0] for exactly the one cycle after the write. Bit 0 is transmit request, bit 1 abort, bit 2 release receive buffer, bit 3 clear overrun, bit 4 self-receive and bit 5 bus-off request. The word reads 0.
- R5: Status is at word 0x02. Bits 7:0 show `eng_status_i` as sampled one cycle earlier. When event bit 7 (bus error) pulses, bits 23:16 capture {type[1:0], rx direction, segment[4:0]}. Otherwise those bits hold.
- R6: The flags at word 0x03 set on `evt_i`, bit for bit: 0 receive, 1 transmit, 2 warning, 3 overrun, 4 wakeup, 5 passive, 6 arbitration lost, 7 bus error. Writing 1 to a flag clears it. If an event and its clear arrive in the same cycle, the event wins.
- R7: Enables are at word 0x04, using the same bit positions as the flags. `irq_o` is high exactly while some flag and its enable are both 1.
- R8: The error counters are at word 0x07, with transmit count in bits 7:0 and receive count in bits 23:16. A bus write stores both fields. `ecnt_ld_i` loads both from the engine and wins over a bus write in the same cycle.
- R9: In reset mode, word 0x10 is the 32-bit acceptance code and word 0x11 is the acceptance mask. Both are writable only in reset mode. In reset mode the other window words read 0.
- R10: In operating mode, window word 0x10+k (k < 13) stores wdata[7:0] as transmit byte k on a write. A read returns receive byte k, which the engine loads through `rx_we_i`. `tx_byte_o` presents transmit byte `tx_idx_i`.
- R11: The transmit header is decoded from the stored bytes. Byte 0 gives extended flag bit 7, remote flag bit 6 and length bits 3:0. An extended id is {b1, b2, b3, b4[7:3]}. A standard id is {b1, b2[7:5]}, zero-extended.
- R12: Read data appears on `bus_rdata_o` the cycle after `bus_rd_i`. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| evt_i | input | 8 | Engine event pulses |
| eng_status_i | input | 8 | Engine live status bits |
| berr_kind_i | input | 2 | Bus error type |
| berr_rx_i | input | 1 | Bus error happened while receiving |
| berr_seg_i | input | 5 | Frame segment code of bus error |
| ecnt_ld_i | input | 1 | Load error counters from engine |
| ecnt_tx_i | input | 8 | Engine transmit error count |
| ecnt_rx_i | input | 8 | Engine receive error count |
| rx_we_i | input | 1 | Receive byte write strobe |
| rx_idx_i | input | BUF_IDX_W | Receive byte index |
| rx_byte_i | input | 8 | Receive byte value |
| tx_idx_i | input | BUF_IDX_W | Transmit byte index |
| tx_byte_o | output | 8 | Transmit byte at tx_idx_i |
| cmd_o | output | 6 | Command pulses |
| mode_o | output | 5 | Mode bits |
| btime_o | output | 24 | Bit timing fields |
| ewl_o | output | 8 | Error warning limit |
| acc_code_o | output | 32 | Acceptance code |
| acc_mask_o | output | 32 | Acceptance mask |
| tx_ext_o | output | 1 | Transmit header extended flag |
| tx_rtr_o | output | 1 | Transmit header remote flag |
| tx_dlc_o | output | 4 | Transmit header data length |
| tx_id_o | output | 29 | Transmit header identifier |

## Verification
The bench builds the block with its default parameters: ADDR_W = 7 and BUF_WORDS = 13. With that setting every slot of the window is small enough to sweep, both for transmit writes and for receive loads. The bench also applies all 64 command codes. For each of the 8 flag bits it checks setting, masking by the enable and clearing one at a time. The transitions into and out of reset mode are driven in both directions, with mixed upper mode bits.

// File: rtl/can_regif_pkg.sv
package can_regif_pkg;
  localparam int unsigned W_MODE  = 0;
  localparam int unsigned W_CMD   = 1;
  localparam int unsigned W_STAT  = 2;
  localparam int unsigned W_IFLAG = 3;
  localparam int unsigned W_IEN   = 4;
  localparam int unsigned W_BTIME = 5;
  localparam int unsigned W_EWL   = 6;
  localparam int unsigned W_ECNT  = 7;
  localparam int unsigned W_WIN   = 16;

  localparam int unsigned MODE_W   = 5;
  localparam int unsigned CMD_W    = 6;
  localparam int unsigned IRQ_W    = 8;
  localparam int unsigned IRQ_BERR = 7;

  localparam logic [23:0]       BT_MASK  = 24'hFF_C3FF;
  localparam logic [7:0]        STAT_RST = 8'h3C;
  localparam logic [7:0]        EWL_RST  = 8'd96;
  localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(1);

  typedef struct packed {
    logic [1:0] kind;
    logic       rx_dir;
    logic [4:0] seg;
  } berr_cap_t;
endpackage

// File: rtl/can_cfg_regs.sv
module can_cfg_regs
  import can_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_mode_i,
  input  logic              we_bt_i,
  input  logic              we_ewl_i,
  input  logic              we_acode_i,
  input  logic              we_amask_i,
  input  logic              we_ecnt_i,
  input  logic [31:0]       wdata_i,
  input  logic              ecnt_ld_i,
  input  logic [7:0]        ecnt_tx_i,
  input  logic [7:0]        ecnt_rx_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [23:0]       btime_o,
  output logic [7:0]        ewl_o,
  output logic [31:0]       acode_o,
  output logic [31:0]       amask_o,
  output logic [7:0]        tec_o,
  output logic [7:0]        rec_o
);
  logic [MODE_W-1:0] mode_q;
  logic [23:0]       bt_q;
  logic [7:0]        ewl_q, tec_q, rec_q;
  logic [31:0]       acode_q, amask_q;
  logic              cfg_open;

  // configuration is open only while reset mode is held
  assign cfg_open = mode_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RST;
      bt_q    <= '0;
      ewl_q   <= EWL_RST;
      acode_q <= '0;
      amask_q <= '0;
      tec_q   <= '0;
      rec_q   <= '0;
    end else begin
      if (we_mode_i) begin
        mode_q[0] <= wdata_i[0];
        if (cfg_open) mode_q[MODE_W-1:1] <= wdata_i[MODE_W-1:1];
      end
      if (we_bt_i && cfg_open)    bt_q    <= wdata_i[23:0] & BT_MASK;
      if (we_ewl_i && cfg_open)   ewl_q   <= wdata_i[7:0];
      if (we_acode_i && cfg_open) acode_q <= wdata_i;
      if (we_amask_i && cfg_open) amask_q <= wdata_i;
      if (ecnt_ld_i) begin
        tec_q <= ecnt_tx_i;
        rec_q <= ecnt_rx_i;
      end else if (we_ecnt_i) begin
        tec_q <= wdata_i[7:0];
        rec_q <= wdata_i[23:16];
      end
    end
  end

  assign mode_o  = mode_q;
  assign btime_o = bt_q;
  assign ewl_o   = ewl_q;
  assign acode_o = acode_q;
  assign amask_o = amask_q;
  assign tec_o   = tec_q;
  assign rec_o   = rec_q;

  p_btime_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_bt_i && !cfg_open) |=> $stable(bt_q));
  p_mode_upper_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_mode_i && !cfg_open) |=> (mode_q[MODE_W-1:1] == $past(mode_q[MODE_W-1:1])));
  p_acc_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open) |=> ($stable(acode_q) && $stable(amask_q)));
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, en_q, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i : '0;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           flag_q[g] <= 1'b0;
      else if (evt_i[g])     flag_q[g] <= 1'b1;  // event beats clear
      else if (clr_mask[g])  flag_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= wdata_i;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign irq_o  = |(flag_q & en_q);

  p_evt_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));
  p_clr_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask != '0) |=> ((flag_q & $past(clr_mask & ~evt_i)) == '0));
  p_no_spurious_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i == '0) |=> ((flag_q & ~$past(flag_q)) == '0));
endmodule

// File: rtl/can_frame_buf.sv
module can_frame_buf #(
  parameter int unsigned DEPTH = 13,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_we_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic [7:0]       wbyte_i,
  input  logic             rx_we_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  input  logic [7:0]       rx_byte_i,
  input  logic [IDX_W-1:0] tx_idx_i,
  output logic [7:0]       rd_byte_o,
  output logic [7:0]       tx_byte_o,
  output logic             ext_o,
  output logic             rtr_o,
  output logic [3:0]       dlc_o,
  output logic [28:0]      id_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [7:0] tx_q [DEPTH];
  logic [7:0] rx_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_q[g] <= '0;
        rx_q[g] <= '0;
      end else begin
        if (win_we_i && win_idx_i == IDX_W'(g)) tx_q[g] <= wbyte_i;
        if (rx_we_i && rx_idx_i == IDX_W'(g))   rx_q[g] <= rx_byte_i;
      end
    end
  end

  assign rd_byte_o = (win_idx_i <= LAST) ? rx_q[win_idx_i] : '0;
  assign tx_byte_o = (tx_idx_i <= LAST) ? tx_q[tx_idx_i] : '0;

  assign ext_o = tx_q[0][7];
  assign rtr_o = tx_q[0][6];
  assign dlc_o = tx_q[0][3:0];
  assign id_o  = ext_o ? {tx_q[1], tx_q[2], tx_q[3], tx_q[4][7:3]}
                       : {18'b0, tx_q[1], tx_q[2][7:5]};

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_we_i) |=> ($stable(id_o) && $stable(dlc_o) && $stable(ext_o) && $stable(rtr_o)));
endmodule

// File: rtl/can_regif.sv
module can_regif
  import can_regif_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned BUF_WORDS = 13,
  parameter int unsigned BUF_IDX_W = $clog2(BUF_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o,
  input  logic [7:0]           evt_i,
  input  logic [7:0]           eng_status_i,
  input  logic [1:0]           berr_kind_i,
  input  logic                 berr_rx_i,
  input  logic [4:0]           berr_seg_i,
  input  logic                 ecnt_ld_i,
  input  logic [7:0]           ecnt_tx_i,
  input  logic [7:0]           ecnt_rx_i,
  input  logic                 rx_we_i,
  input  logic [BUF_IDX_W-1:0] rx_idx_i,
  input  logic [7:0]           rx_byte_i,
  input  logic [BUF_IDX_W-1:0] tx_idx_i,
  output logic [7:0]           tx_byte_o,
  output logic [5:0]           cmd_o,
  output logic [4:0]           mode_o,
  output logic [23:0]          btime_o,
  output logic [7:0]           ewl_o,
  output logic [31:0]          acc_code_o,
  output logic [31:0]          acc_mask_o,
  output logic                 tx_ext_o,
  output logic                 tx_rtr_o,
  output logic [3:0]           tx_dlc_o,
  output logic [28:0]          tx_id_o
);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(W_MODE);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(W_CMD);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(W_STAT);
  localparam logic [ADDR_W-1:0] A_IFLAG = ADDR_W'(W_IFLAG);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(W_IEN);
  localparam logic [ADDR_W-1:0] A_BTIME = ADDR_W'(W_BTIME);
  localparam logic [ADDR_W-1:0] A_EWL   = ADDR_W'(W_EWL);
  localparam logic [ADDR_W-1:0] A_ECNT  = ADDR_W'(W_ECNT);
  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(W_WIN);
  localparam logic [ADDR_W-1:0] A_WIN1  = ADDR_W'(W_WIN + 1);
  localparam logic [ADDR_W-1:0] A_WEND  = ADDR_W'(W_WIN + BUF_WORDS - 1);

  logic [MODE_W-1:0]    mode;
  logic [23:0]          bt;
  logic [7:0]           ewl, tec, rec;
  logic [31:0]          acode, amask;
  logic [IRQ_W-1:0]     flags, ens;
  logic [7:0]           rx_rd_byte;
  logic                 in_win, rst_mode;
  logic [BUF_IDX_W-1:0] win_k;
  logic                 cmd_we;
  logic [CMD_W-1:0]     cmd_q;
  logic [7:0]           sta_q;
  berr_cap_t            ecap_q;
  logic [31:0]          rd_mux, rdata_q;

  assign rst_mode = mode[0];
  assign in_win   = (bus_addr_i >= A_WIN) && (bus_addr_i <= A_WEND);
  assign win_k    = BUF_IDX_W'(bus_addr_i - A_WIN);
  assign cmd_we   = bus_wr_i && (bus_addr_i == A_CMD);

  can_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_mode_i  (bus_wr_i && bus_addr_i == A_MODE),
    .we_bt_i    (bus_wr_i && bus_addr_i == A_BTIME),
    .we_ewl_i   (bus_wr_i && bus_addr_i == A_EWL),
    .we_acode_i (bus_wr_i && bus_addr_i == A_WIN),
    .we_amask_i (bus_wr_i && bus_addr_i == A_WIN1),
    .we_ecnt_i  (bus_wr_i && bus_addr_i == A_ECNT),
    .wdata_i    (bus_wdata_i),
    .ecnt_ld_i  (ecnt_ld_i),
    .ecnt_tx_i  (ecnt_tx_i),
    .ecnt_rx_i  (ecnt_rx_i),
    .mode_o     (mode),
    .btime_o    (bt),
    .ewl_o      (ewl),
    .acode_o    (acode),
    .amask_o    (amask),
    .tec_o      (tec),
    .rec_o      (rec)
  );

  can_irq_ctrl #(.N(IRQ_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_we_i (bus_wr_i && bus_addr_i == A_IFLAG),
    .en_we_i  (bus_wr_i && bus_addr_i == A_IEN),
    .wdata_i  (bus_wdata_i[IRQ_W-1:0]),
    .flag_o   (flags),
    .en_o     (ens),
    .irq_o    (irq_o)
  );

  can_frame_buf #(.DEPTH(BUF_WORDS), .IDX_W(BUF_IDX_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_we_i  (bus_wr_i && in_win && !rst_mode),
    .win_idx_i (win_k),
    .wbyte_i   (bus_wdata_i[7:0]),
    .rx_we_i   (rx_we_i),
    .rx_idx_i  (rx_idx_i),
    .rx_byte_i (rx_byte_i),
    .tx_idx_i  (tx_idx_i),
    .rd_byte_o (rx_rd_byte),
    .tx_byte_o (tx_byte_o),
    .ext_o     (tx_ext_o),
    .rtr_o     (tx_rtr_o),
    .dlc_o     (tx_dlc_o),
    .id_o      (tx_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      sta_q  <= STAT_RST;
      ecap_q <= '0;
    end else begin
      cmd_q <= cmd_we ? bus_wdata_i[CMD_W-1:0] : '0;
      sta_q <= eng_status_i;
      if (evt_i[IRQ_BERR]) ecap_q <= '{kind: berr_kind_i, rx_dir: berr_rx_i, seg: berr_seg_i};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr_i == A_MODE)       rd_mux = 32'(mode);
    else if (bus_addr_i == A_STAT)  rd_mux = {8'b0, ecap_q, 8'b0, sta_q};
    else if (bus_addr_i == A_IFLAG) rd_mux = 32'(flags);
    else if (bus_addr_i == A_IEN)   rd_mux = 32'(ens);
    else if (bus_addr_i == A_BTIME) rd_mux = 32'(bt);
    else if (bus_addr_i == A_EWL)   rd_mux = 32'(ewl);
    else if (bus_addr_i == A_ECNT)  rd_mux = {8'b0, rec, 8'b0, tec};
    else if (in_win) begin
      if (!rst_mode)                  rd_mux = 32'(rx_rd_byte);
      else if (bus_addr_i == A_WIN)   rd_mux = acode;
      else if (bus_addr_i == A_WIN1)  rd_mux = amask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign cmd_o       = cmd_q;
  assign mode_o      = mode;
  assign btime_o     = bt;
  assign ewl_o       = ewl;
  assign acc_code_o  = acode;
  assign acc_mask_o  = amask;

  p_cmd_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q != '0) |-> $past(cmd_we));
  p_ecap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i[IRQ_BERR]) |=> $stable(ecap_q));
  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rd_i) |=> $stable(rdata_q));
endmodule

// File: tb/tb_can_regif.sv
module tb_can_regif;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        wr, rd;
  logic [6:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  logic [7:0]  evt, est;
  logic [1:0]  bkind;
  logic        brx;
  logic [4:0]  bseg;
  logic        eld;
  logic [7:0]  etx, erx;
  logic        rxwe;
  logic [3:0]  rxidx, txidx;
  logic [7:0]  rxb, txb;
  logic [5:0]  cmd;
  logic [4:0]  mode;
  logic [23:0] btime;
  logic [7:0]  ewl;
  logic [31:0] acode, amask;
  logic        text, trtr;
  logic [3:0]  tdlc;
  logic [28:0] tid;

  int checks = 0;
  int errors = 0;
  logic [31:0] r;

  can_regif dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .evt_i(evt),
    .eng_status_i(est), .berr_kind_i(bkind), .berr_rx_i(brx), .berr_seg_i(bseg),
    .ecnt_ld_i(eld), .ecnt_tx_i(etx), .ecnt_rx_i(erx), .rx_we_i(rxwe),
    .rx_idx_i(rxidx), .rx_byte_i(rxb), .tx_idx_i(txidx), .tx_byte_o(txb),
    .cmd_o(cmd), .mode_o(mode), .btime_o(btime), .ewl_o(ewl),
    .acc_code_o(acode), .acc_mask_o(amask), .tx_ext_o(text), .tx_rtr_o(trtr),
    .tx_dlc_o(tdlc), .tx_id_o(tid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic rx_load(input logic [3:0] k, input logic [7:0] b);
    @(negedge clk); rxwe = 1'b1; rxidx = k; rxb = b;
    @(negedge clk); rxwe = 1'b0;
  endtask

  task automatic tx_peek(input logic [3:0] k, output logic [7:0] b);
    txidx = k; #1; b = txb;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    rst_n = 0; wr = 0; rd = 0; addr = '0; wdata = '0; evt = '0; est = 8'h3C;
    bkind = '0; brx = 0; bseg = '0; eld = 0; etx = '0; erx = '0;
    rxwe = 0; rxidx = '0; rxb = '0; txidx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    bus_rd(7'h00, r); chk("R1 mode", r, 32'h1);
    bus_rd(7'h02, r); chk("R1 status", r, 32'h3C);
    bus_rd(7'h03, r); chk("R1 flags", r, 32'h0);
    bus_rd(7'h04, r); chk("R1 enables", r, 32'h0);
    bus_rd(7'h05, r); chk("R1 timing", r, 32'h0);
    bus_rd(7'h06, r); chk("R1 ewl", r, 32'h60);
    bus_rd(7'h07, r); chk("R1 ecnt", r, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R3 configuration in reset mode
    bus_wr(7'h05, 32'hFFFF_FFFF); bus_rd(7'h05, r); chk("R3 timing mask", r, 32'h00FF_C3FF);
    chk("R3 btime_o", 32'(btime), 32'h00FF_C3FF);
    bus_wr(7'h06, 32'h0000_01A3); bus_rd(7'h06, r); chk("R3 ewl", r, 32'hA3);

    // R9 acceptance registers
    bus_wr(7'h10, 32'h1234_5678); bus_wr(7'h11, 32'h9ABC_DEF0);
    bus_rd(7'h10, r); chk("R9 code", r, 32'h1234_5678);
    bus_rd(7'h11, r); chk("R9 mask", r, 32'h9ABC_DEF0);
    chk("R9 code out", acode, 32'h1234_5678);
    chk("R9 mask out", amask, 32'h9ABC_DEF0);
    bus_rd(7'h12, r); chk("R9 other window word", r, 32'h0);

    // R2 mode gating, both directions
    bus_wr(7'h00, 32'h1F); bus_rd(7'h00, r); chk("R2 set all in reset", r, 32'h1F);
    chk("R2 mode_o", 32'(mode), 32'h1F);
    bus_wr(7'h00, 32'h00); bus_rd(7'h00, r); chk("R2 leave reset", r, 32'h00);
    bus_wr(7'h00, 32'h1E); bus_rd(7'h00, r); chk("R2 upper locked", r, 32'h00);
    bus_wr(7'h00, 32'h1F); bus_rd(7'h00, r); chk("R2 enter reset only", r, 32'h01);
    bus_wr(7'h00, 32'h00); bus_rd(7'h00, r); chk("R2 operating", r, 32'h00);

    // R3/R9 locked in operating mode
    bus_wr(7'h05, 32'h0); bus_rd(7'h05, r); chk("R3 timing locked", r, 32'h00FF_C3FF);
    bus_wr(7'h06, 32'h11); bus_rd(7'h06, r); chk("R3 ewl locked", r, 32'hA3);
    bus_wr(7'h10, 32'hFFFF_FF5A);
    chk("R9 code untouched", acode, 32'h1234_5678);
    tx_peek(4'd0, b); chk("R10 word0 to tx", 32'(b), 32'h5A);

    // R10 window sweep
    for (int k = 0; k < 13; k++) bus_wr(7'(16 + k), {24'hABCDEF, 8'((k * 17 + 3) & 255)});
    for (int k = 0; k < 13; k++) begin
      tx_peek(4'(k), b); chk("R10 tx byte", 32'(b), 32'((k * 17 + 3) & 255));
    end
    for (int k = 0; k < 13; k++) rx_load(4'(k), 8'((k * 29 + 5) & 255));
    for (int k = 0; k < 13; k++) begin
      bus_rd(7'(16 + k), r); chk("R10 rx read", r, 32'((k * 29 + 5) & 255));
    end
    tx_peek(4'd5, b); chk("R10 tx separate from rx", 32'(b), 32'((5 * 17 + 3) & 255));

    // R11 header decode
    bus_wr(7'h10, 32'h88); bus_wr(7'h11, 32'hAB); bus_wr(7'h12, 32'hCD);
    bus_wr(7'h13, 32'hEF); bus_wr(7'h14, 32'h95);
    chk("R11 ext", 32'(text), 32'h1);
    chk("R11 rtr ext", 32'(trtr), 32'h0);
    chk("R11 dlc", 32'(tdlc), 32'h8);
    chk("R11 ext id", 32'(tid), (32'hABCDEF << 5) | (32'h95 >> 3));
    bus_wr(7'h10, 32'h43);
    chk("R11 std flags", {30'b0, text, trtr}, 32'h1);
    chk("R11 std dlc", 32'(tdlc), 32'h3);
    chk("R11 std id", 32'(tid), (32'hAB << 3) | (32'hCD >> 5));

    // R4 command pulses
    for (int v = 0; v < 64; v++) begin
      bus_wr(7'h01, 32'hFFFF_FFC0 | 32'(v));
      chk("R4 pulse", 32'(cmd), 32'(v));
      @(negedge clk); chk("R4 one cycle", 32'(cmd), 32'h0);
    end
    bus_rd(7'h01, r); chk("R4 reads zero", r, 32'h0);

    // R5 status
    est = 8'hA5; @(negedge clk);
    bus_rd(7'h02, r); chk("R5 live bits", r, 32'h0000_00A5);
    bkind = 2'd2; brx = 1'b1; bseg = 5'h0A;
    pulse_evt(8'h80);
    bus_rd(7'h02, r); chk("R5 capture", r, 32'h00AA_00A5);
    bkind = 2'd1; brx = 1'b0; bseg = 5'h1F; @(negedge clk);
    bus_rd(7'h02, r); chk("R5 hold", r, 32'h00AA_00A5);
    bus_wr(7'h03, 32'hFF);

    // R6/R7 flag and enable sweep
    for (int k = 0; k < 8; k++) begin
      bus_wr(7'h04, 32'(1 << k));
      pulse_evt(8'hFF & ~8'(1 << k));
      chk("R7 masked", 32'(irq), 32'h0);
      pulse_evt(8'(1 << k));
      chk("R7 raised", 32'(irq), 32'h1);
      bus_rd(7'h03, r); chk("R6 all set", r, 32'hFF);
      bus_wr(7'h03, 32'(1 << k));
      chk("R7 dropped", 32'(irq), 32'h0);
      bus_rd(7'h03, r); chk("R6 single clear", r, 32'(8'hFF & ~8'(1 << k)));
      bus_wr(7'h03, 32'hFF);
      bus_rd(7'h03, r); chk("R6 clear all", r, 32'h0);
    end
    pulse_evt(8'hFF);
    @(negedge clk); evt = 8'h05; wr = 1'b1; addr = 7'h03; wdata = 32'hFF;
    @(negedge clk); evt = '0; wr = 1'b0;
    bus_rd(7'h03, r); chk("R6 event wins", r, 32'h05);

    // R8 error counters
    @(negedge clk); eld = 1'b1; etx = 8'h33; erx = 8'h7E;
    @(negedge clk); eld = 1'b0;
    bus_rd(7'h07, r); chk("R8 load", r, 32'h007E_0033);
    bus_wr(7'h07, 32'h0); bus_rd(7'h07, r); chk("R8 clear", r, 32'h0);
    @(negedge clk); eld = 1'b1; etx = 8'h11; erx = 8'h22; wr = 1'b1; addr = 7'h07; wdata = 32'h0;
    @(negedge clk); eld = 1'b0; wr = 1'b0;
    bus_rd(7'h07, r); chk("R8 load wins", r, 32'h0022_0011);

    // R12 unmapped and latency
    bus_rd(7'h08, r); chk("R12 unmapped", r, 32'h0);
    bus_rd(7'h7F, r); chk("R12 past window", r, 32'h0);
    bus_rd(7'h06, r);
    bus_wr(7'h00, 32'h01);
    chk("R12 rdata held", rdata, 32'hA3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule